// File: doc/BRIEF.md
# Display-Memory Read Prefetch Unit

This block serves data-port reads of display memory from words that it has already fetched. The host loads an access code and a byte address. Whenever the write FIFO leaves an external access slot unused, the block uses that slot to read ahead from VRAM, CRAM or VSRAM. A later data-port read then completes as soon as a fetched word is on hand. After each read the address moves on by the auto-increment amount, and the next word is fetched ahead in the same way.

VRAM is byte-wide, so a full word read from it takes two slots. The narrower colour and scroll memories store only some bits of each word. The block fills the bits they do not store from the value of the most recent FIFO entry. Scroll-memory indices past the last entry fall back to entry zero.

Top module: `rd_prefetch`

## Requirements
- R1: A fetch happens only in a cycle with `slot_free` high, a read code (code bit 0 clear) and no fetched word held. The read codes are 4'b0000 (VRAM word), 4'b1100 (VRAM byte), 4'b1000 (CRAM) and 4'b0100 (VSRAM). Any other even code fetches nothing. At most one memory read enable is high in a cycle.
- R2: A VRAM word read uses two fetch slots. The first slot reads the byte at `addr & 16'hFFFE` into result bits 15:8. The second slot reads the byte at `addr | 1` into bits 7:0 and marks the word fetched.
- R3: A VRAM byte read uses one slot. It places the byte at `addr ^ 1` in bits 7:0 and `fifo_last[15:8]` in bits 15:8.
- R4: A CRAM read uses index `(addr >> 1) mod CRAM_N`. It keeps the stored bits under mask 16'h0EEE and takes every other bit from `fifo_last`.
- R5: A VSRAM read computes index `(addr >> 1) & 63` and uses index 0 in its place when that value is `>= VSRAM_N`. It keeps the stored bits under 16'h07FF and takes bits under 16'hF800 from `fifo_last`. Bits 15:0 outside both masks are zero.
- R6: A read request while the code is a write code (bit 0 set) returns 16'h0000 on the next cycle and leaves the address unchanged.
- R7: Otherwise a read request waits until a word is fetched. In the cycle after the fetched word is seen, `rd_valid` rises with that word. The fetched flag is then cleared and `auto_inc` is added to the address, so the next prefetch uses the new address.
- R8: `rd_valid` and `rd_data` stay unchanged until a cycle with `rd_ready` high, which ends the transfer.
- R9: `addr_load` takes in `code_in` and `addr_in` and throws away any fetched or half-fetched word. It is ignored while a read is in flight. A `rd_req` in the same cycle as an accepted load is ignored.
- R10: After reset, no read is in flight, `rd_valid` is low and the code is a write code, so no fetch is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load a new code and address |
| code_in | input | 4 | Access code to load |
| addr_in | input | AW | Byte address to load |
| auto_inc | input | 8 | Amount added to the address after each read |
| slot_free | input | 1 | The current access slot is unused by the write FIFO |
| fifo_last | input | 16 | Value of the most recent FIFO entry |
| vram_re | output | 1 | VRAM read enable |
| vram_addr | output | AW | VRAM byte address |
| vram_rdata | input | 8 | VRAM read data (combinational from address) |
| cram_re | output | 1 | CRAM read enable |
| cram_addr | output | CW | CRAM index |
| cram_rdata | input | 16 | CRAM read data |
| vsram_re | output | 1 | VSRAM read enable |
| vsram_addr | output | 6 | VSRAM index |
| vsram_rdata | input | 16 | VSRAM read data |
| rd_req | input | 1 | Data-port read request pulse |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 16 | Read data |
| rd_ready | input | 1 | Host accepts read data |

## Verification
The read handoff and the next prefetch can fall in the same cycle. A free slot may arrive in the very cycle that a fetched word is handed to the read port and the address advances. The bench provokes this by holding `slot_free` high through back-to-back reads with `rd_ready` asserted at once. It judges the result by the words returned for successive auto-incremented addresses: each one must come from the advanced address and never repeat or skip a word. A second collision, a load arriving while a read is stalled, is judged by checking that the stalled read returns data from the old address.

// File: rtl/rd_prefetch.sv
module rd_prefetch #(
  parameter int AW = 16,
  parameter int CRAM_N = 64,
  parameter int VSRAM_N = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [3:0]    code_in,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    auto_inc,
  input  logic          slot_free,
  input  logic [15:0]   fifo_last,
  output logic          vram_re,
  output logic [AW-1:0] vram_addr,
  input  logic [7:0]    vram_rdata,
  output logic          cram_re,
  output logic [$clog2(CRAM_N)-1:0] cram_addr,
  input  logic [15:0]   cram_rdata,
  output logic          vsram_re,
  output logic [5:0]    vsram_addr,
  input  logic [15:0]   vsram_rdata,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  input  logic          rd_ready
);
  localparam int CW = $clog2(CRAM_N);
  localparam logic [15:0] CMASK = 16'h0EEE;
  localparam logic [15:0] VMASK = 16'h07FF;
  localparam logic [15:0] VFILL = 16'hF800;
  localparam logic [3:0] C_VWORD = 4'b0000, C_VBYTE = 4'b1100,
                         C_CRAM = 4'b1000, C_VSRAM = 4'b0100;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_VALID} st_t;
  st_t st;

  logic [AW-1:0] addr;
  logic [3:0]    code;
  logic [15:0]   pf;
  logic          fetched, half;

  logic load_ok, fetch_go, is_vw, is_vb, is_cr, is_vs;
  logic [5:0] vs_raw;

  assign load_ok  = addr_load && (st == S_IDLE);
  assign is_vw    = (code == C_VWORD);
  assign is_vb    = (code == C_VBYTE);
  assign is_cr    = (code == C_CRAM);
  assign is_vs    = (code == C_VSRAM);
  assign fetch_go = slot_free && !code[0] && !fetched && !load_ok;

  assign vram_re  = fetch_go && (is_vw || is_vb);
  assign cram_re  = fetch_go && is_cr;
  assign vsram_re = fetch_go && is_vs;

  assign vram_addr  = is_vb ? (addr ^ AW'(1)) :
                      half  ? (addr | AW'(1)) : (addr & ~AW'(1));
  assign cram_addr  = addr[CW:1];
  assign vs_raw     = addr[6:1];
  assign vsram_addr = (int'(vs_raw) >= VSRAM_N) ? 6'd0 : vs_raw;
  assign rd_valid   = (st == S_VALID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr    <= '0;
      code    <= 4'b0001;
      pf      <= '0;
      fetched <= 1'b0;
      half    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (load_ok) begin
        addr    <= addr_in;
        code    <= code_in;
        fetched <= 1'b0;
        half    <= 1'b0;
      end else if (vram_re && is_vw) begin
        if (!half) begin
          pf   <= {vram_rdata, 8'h00};
          half <= 1'b1;
        end else begin
          pf[7:0] <= vram_rdata;
          half    <= 1'b0;
          fetched <= 1'b1;
        end
      end else if (vram_re) begin
        pf      <= {fifo_last[15:8], vram_rdata};
        fetched <= 1'b1;
      end else if (cram_re) begin
        pf      <= (cram_rdata & CMASK) | (fifo_last & ~CMASK);
        fetched <= 1'b1;
      end else if (vsram_re) begin
        pf      <= (vsram_rdata & VMASK) | (fifo_last & VFILL);
        fetched <= 1'b1;
      end

      case (st)
        S_IDLE: if (rd_req && !addr_load) begin
          if (code[0]) begin
            rd_data <= '0;
            st      <= S_VALID;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (fetched) begin
          rd_data <= pf;
          fetched <= 1'b0;
          addr    <= addr + AW'(auto_inc);
          st      <= S_VALID;
        end
        S_VALID: if (rd_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_re, cram_re, vsram_re}));

  assert_half_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetched && half));

  assert_vsram_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsram_re |-> (int'(vsram_addr) < VSRAM_N));

  assert_valid_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && fetched) |=> rd_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VALID && addr_load) |=> $stable(code));
endmodule

// File: tb/tb_rd_prefetch.sv
module tb_rd_prefetch;
  localparam int AW = 16, CRAM_N = 64, VSRAM_N = 40;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, slot_free = 0, rd_req = 0, rd_ready = 0;
  logic [3:0] code_in = 0;
  logic [15:0] addr_in = 0, fifo_last = 0;
  logic [7:0] auto_inc = 0;
  logic vram_re, cram_re, vsram_re, rd_valid;
  logic [15:0] vram_addr, cram_rdata, vsram_rdata, rd_data;
  logic [5:0] cram_addr, vsram_addr;
  logic [7:0] vram_rdata;
  int slot_mode = 2;
  int vectors = 0, miscompares = 0, cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] vb(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction
  function automatic logic [15:0] cm(int i);
    return 16'(i * 16'h0913 + 16'h7001);
  endfunction
  function automatic logic [15:0] vs(int i);
    return 16'(i * 16'h1357 + 16'hB00B);
  endfunction
  function automatic logic [15:0] expect_word(logic [3:0] c, logic [15:0] a, logic [15:0] fl);
    int idx;
    case (c)
      4'b0000: return {vb(a & 16'hFFFE), vb(a | 16'h1)};
      4'b1100: return {fl[15:8], vb(a ^ 16'h1)};
      4'b1000: begin idx = (a >> 1) % CRAM_N;
        return (cm(idx) & 16'h0EEE) | (fl & ~16'h0EEE); end
      4'b0100: begin idx = (a >> 1) & 63; if (idx >= VSRAM_N) idx = 0;
        return (vs(idx) & 16'h07FF) | (fl & 16'hF800); end
      default: return 16'h0000;
    endcase
  endfunction

  assign vram_rdata  = vb(vram_addr);
  assign cram_rdata  = cm(int'(cram_addr));
  assign vsram_rdata = vs(int'(vsram_addr));

  rd_prefetch #(.AW(AW), .CRAM_N(CRAM_N), .VSRAM_N(VSRAM_N)) dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .code_in(code_in),
    .addr_in(addr_in), .auto_inc(auto_inc), .slot_free(slot_free),
    .fifo_last(fifo_last), .vram_re(vram_re), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .cram_re(cram_re), .cram_addr(cram_addr),
    .cram_rdata(cram_rdata), .vsram_re(vsram_re), .vsram_addr(vsram_addr),
    .vsram_rdata(vsram_rdata), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready));

  always @(negedge clk)
    slot_free <= (slot_mode == 1) || (slot_mode == 0 && ($urandom % 3 == 0));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic load(logic [3:0] c, logic [15:0] a, logic [15:0] fl, logic [7:0] inc);
    @(negedge clk);
    addr_load = 1; code_in = c; addr_in = a; fifo_last = fl; auto_inc = inc;
    @(negedge clk);
    addr_load = 0;
  endtask

  task automatic do_read(string req, logic [15:0] exp, int hold);
    logic [15:0] first;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    while (!rd_valid) @(negedge clk);
    first = rd_data;
    repeat (hold) begin
      @(negedge clk);
      if (!rd_valid || rd_data !== first)
        check("R8", rd_data, first);
    end
    check(req, rd_data, exp);
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
  endtask

  task automatic seq(string req, logic [3:0] c, logic [15:0] a, logic [15:0] fl,
                     logic [7:0] inc, int n, int mode);
    logic [15:0] cur = a;
    slot_mode = mode;
    load(c, a, fl, inc);
    for (int k = 0; k < n; k++) begin
      do_read(req, expect_word(c, cur, fl), (mode == 1 && k > 0) ? 0 : int'($urandom % 3));
      if (!c[0]) cur = cur + 16'(inc);
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    slot_mode = 1;
    @(negedge clk); rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      check("R10", {13'd0, vram_re, cram_re, vsram_re}, 16'd0);
      check("R10", {15'd0, rd_valid}, 16'd0);
    end

    seq("R2", 4'b0000, 16'h1235, 16'hAAAA, 8'd2, 3, 1);
    seq("R2", 4'b0000, 16'hFFFE, 16'h0, 8'd2, 2, 0);
    seq("R3", 4'b1100, 16'h4000, 16'h5A3C, 8'd1, 3, 0);
    seq("R4", 4'b1000, 16'h007E, 16'hFFFF, 8'd2, 3, 1);
    seq("R4", 4'b1000, 16'h0080, 16'h1234, 8'd0, 2, 0);
    seq("R5", 4'b0100, 16'h004E, 16'hFFFF, 8'd2, 3, 1);
    seq("R5", 4'b0100, 16'h007E, 16'h8001, 8'd2, 2, 0);
    seq("R6", 4'b0001, 16'h2222, 16'h0, 8'd2, 2, 1);
    seq("R6", 4'b0011, 16'h3333, 16'hFFFF, 8'd2, 1, 0);
    seq("R7", 4'b1100, 16'h0100, 16'hC300, 8'd1, 6, 1);
    seq("R7", 4'b0000, 16'h0200, 16'h0, 8'd0, 3, 0);

    slot_mode = 2;
    load(4'b0000, 16'h0420, 16'h0, 8'd2);
    repeat (4) @(negedge clk);
    check("R1", {13'd0, vram_re, cram_re, vsram_re}, 16'd0);
    slot_mode = 1;
    load(4'b0010, 16'h0420, 16'h0, 8'd2);
    repeat (4) @(negedge clk);
    check("R1", {13'd0, vram_re, cram_re, vsram_re}, 16'd0);

    slot_mode = 2;
    load(4'b1100, 16'h0500, 16'hEE00, 8'd1);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    @(negedge clk); addr_load = 1; code_in = 4'b1000; addr_in = 16'h0900;
    @(negedge clk); addr_load = 0;
    slot_mode = 1;
    while (!rd_valid) @(negedge clk);
    check("R9", rd_data, expect_word(4'b1100, 16'h0500, 16'hEE00));
    rd_ready = 1; @(negedge clk); rd_ready = 0;
    slot_mode = 1;
    load(4'b1100, 16'h0700, 16'h1100, 8'd1);
    repeat (3) @(negedge clk);
    load(4'b0100, 16'h0002, 16'h0000, 8'd2);
    do_read("R9", expect_word(4'b0100, 16'h0002, 16'h0), 0);

    for (int t = 0; t < 40; t++) begin
      logic [3:0] c;
      logic [7:0] inc;
      case ($urandom % 5)
        0: c = 4'b0000; 1: c = 4'b1100; 2: c = 4'b1000; 3: c = 4'b0100;
        default: c = 4'b0101;
      endcase
      case ($urandom % 4)
        0: inc = 8'd0; 1: inc = 8'd1; 2: inc = 8'd2; default: inc = 8'($urandom);
      endcase
      seq("R7", c, 16'($urandom), 16'($urandom), inc, 1 + int'($urandom % 4),
          int'($urandom % 2));
    end
    summary();
  end
endmodule